// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two single-precision IEEE-754 words and produces one condition bit. A four-bit predicate code selects the relation to be tested. Six predicates are ordered relations that are false whenever an operand is NaN. Six are "unordered or relation" forms that are true when an operand is NaN or when the relation holds. The last is a bare unordered test. The result is meant for a status flag that later branch logic reads, so the block writes no data word.

A strobe marks a compare request. When the strobe is high and the predicate code is legal, the block raises a write enable and updates its flag. It also raises an invalid-operation indication when either operand is a signalling NaN. A parameter places a register on the outputs (default) or leaves the result combinational. In both variants the flag holds its last written value until the next legal compare.

Top module: `fcmp_flag_unit`

## Requirements
- R1: Ordered predicates use these codes: 0 equal, 1 not-equal, 2 greater-than, 3 greater-or-equal, 4 less-than, 5 less-or-equal. Each writes its relation of A to B into the flag, and each writes 0 when either operand is NaN (exponent all ones, fraction nonzero).
- R2: +0.0 (0x00000000) and -0.0 (0x80000000) compare as equal, and neither is less than the other.
- R3: Ordering follows sign and magnitude. Any negative non-zero value is below any positive value. For two negative operands, the larger magnitude is the smaller value. Denormals and infinities order by the same rule.
- R4: Codes 8 to 13 are the unordered forms of codes 0 to 5 (bit 3 set). Each writes 1 when either operand is NaN, and otherwise writes the same relation as the ordered form.
- R5: Code 14 writes 1 exactly when at least one operand is NaN.
- R6: flag_invalid is 1 together with a flag write when either operand is a signalling NaN (NaN with fraction bit 22 clear). It is 0 for quiet NaNs (fraction bit 22 set) and for non-NaN operands.
- R7: With the output register present, a strobe carrying a legal code gives flag_we = 1 and the new flag_out on the cycle after the strobe. Codes 6, 7 and 15 give flag_we = 0 and leave flag_out unchanged.
- R8: While rst is high, and in the first cycle after it, flag_out, flag_we and flag_invalid are 0.
- R9: With the strobe low, flag_we and flag_invalid are 0 and flag_out keeps its last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare request strobe |
| cmp_sel | input | 4 | Predicate code |
| opnd_a | input | 32 | Operand A, single-precision bits |
| opnd_b | input | 32 | Operand B, single-precision bits |
| flag_out | output | 1 | Current condition flag |
| flag_we | output | 1 | Flag write enable, high for one result |
| flag_invalid | output | 1 | Signalling-NaN invalid-operation indication |

## Verification
With the default output register, every result (flag_we, flag_out and flag_invalid) is due exactly one clock after the cycle that carries the strobe. The bench drives the strobe on a falling edge for one cycle. It then reads the outputs at the next falling edge, when the capturing rising edge has passed and no new request has been issued. Hold behaviour for illegal codes and idle cycles is read on the same single-cycle schedule, after a known flag has been written.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = EXP_W + FRAC_W;
    localparam int SEL_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        PRED_EQ  = 4'd0,
        PRED_NE  = 4'd1,
        PRED_GT  = 4'd2,
        PRED_GE  = 4'd3,
        PRED_LT  = 4'd4,
        PRED_LE  = 4'd5,
        PRED_UEQ = 4'd8,
        PRED_UNE = 4'd9,
        PRED_UGT = 4'd10,
        PRED_UGE = 4'd11,
        PRED_ULT = 4'd12,
        PRED_ULE = 4'd13,
        PRED_UN  = 4'd14
    } fcmp_pred_e;

    typedef struct packed {
        logic             sign;
        logic             is_zero;
        logic             is_nan;
        logic             is_snan;
        logic [MAG_W-1:0] mag;
    } fcmp_class_t;

    typedef struct packed {
        logic unord;
        logic eq;
        logic lt;
        logic gt;
    } fcmp_rel_t;

    function automatic logic pred_is_legal(input logic [SEL_W-1:0] sel);
        return (sel[2:0] <= 3'd5) || (sel == PRED_UN);
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fcmp_class_t       cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;

    assign exp_f    = word[WORD_W-2 -: EXP_W];
    assign frac_f   = word[FRAC_W-1:0];
    assign exp_ones = &exp_f;

    always_comb begin
        cls.sign    = word[WORD_W-1];
        cls.mag     = word[MAG_W-1:0];
        cls.is_zero = (word[MAG_W-1:0] == '0);
        cls.is_nan  = exp_ones && (frac_f != '0);
        cls.is_snan = exp_ones && (frac_f != '0) && !frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  fcmp_class_t ca,
    input  fcmp_class_t cb,
    output fcmp_rel_t   rel
);
    logic both_zero;
    logic mag_lt;
    logic mag_gt;
    logic mag_eq;
    logic a_below;
    logic a_above;

    assign both_zero = ca.is_zero && cb.is_zero;
    assign mag_lt    = ca.mag < cb.mag;
    assign mag_gt    = ca.mag > cb.mag;
    assign mag_eq    = ca.mag == cb.mag;

    always_comb begin
        if (ca.sign != cb.sign) begin
            a_below = ca.sign;
            a_above = cb.sign;
        end else if (ca.sign) begin
            a_below = mag_gt;
            a_above = mag_lt;
        end else begin
            a_below = mag_lt;
            a_above = mag_gt;
        end
    end

    always_comb begin
        rel.unord = ca.is_nan || cb.is_nan;
        rel.eq    = !rel.unord && (both_zero || (ca.sign == cb.sign && mag_eq));
        rel.lt    = !rel.unord && !both_zero && a_below;
        rel.gt    = !rel.unord && !both_zero && a_above;
    end
endmodule

// File: rtl/fcmp_select.sv
module fcmp_select
    import fcmp_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  fcmp_rel_t        rel,
    output logic             legal,
    output logic             flag
);
    logic base;

    always_comb begin
        unique case (sel[2:0])
            3'd0:    base = rel.eq;
            3'd1:    base = !rel.eq && !rel.unord;
            3'd2:    base = rel.gt;
            3'd3:    base = rel.gt || rel.eq;
            3'd4:    base = rel.lt;
            3'd5:    base = rel.lt || rel.eq;
            default: base = 1'b0;
        endcase
    end

    always_comb begin
        legal = pred_is_legal(sel);
        if (sel == PRED_UN)
            flag = rel.unord;
        else if (sel[3])
            flag = rel.unord || base;
        else
            flag = base;
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_valid,
    input  logic [SEL_W-1:0]  cmp_sel,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    output logic              flag_out,
    output logic              flag_we,
    output logic              flag_invalid
);
    localparam int N_OPND = 2;

    logic [WORD_W-1:0] opnd_arr [N_OPND];
    fcmp_class_t       cls      [N_OPND];
    fcmp_rel_t         rel;
    logic              legal;
    logic              sel_flag;
    logic              we_n;
    logic              inv_n;
    logic              flag_n;
    logic              flag_q;

    assign opnd_arr[0] = opnd_a;
    assign opnd_arr[1] = opnd_b;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
        fcmp_classify u_cls (
            .word (opnd_arr[gi]),
            .cls  (cls[gi])
        );
    end

    fcmp_relate u_rel (
        .ca  (cls[0]),
        .cb  (cls[1]),
        .rel (rel)
    );

    fcmp_select u_sel (
        .sel   (cmp_sel),
        .rel   (rel),
        .legal (legal),
        .flag  (sel_flag)
    );

    assign we_n   = cmp_valid && legal;
    assign inv_n  = we_n && (cls[0].is_snan || cls[1].is_snan);
    assign flag_n = we_n ? sel_flag : flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_n;
    end

    if (REG_OUT) begin : g_reg
        logic we_q;
        logic inv_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                we_q  <= 1'b0;
                inv_q <= 1'b0;
            end else begin
                we_q  <= we_n;
                inv_q <= inv_n;
            end
        end
        assign flag_out     = flag_q;
        assign flag_we      = we_q;
        assign flag_invalid = inv_q;
    end else begin : g_comb
        assign flag_out     = flag_n;
        assign flag_we      = we_n;
        assign flag_invalid = inv_n;
    end
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        cmp_valid,
    input logic [3:0]  cmp_sel,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic        flag_out,
    input logic        flag_we,
    input logic        flag_invalid
);
    logic a_nan, b_nan, a_zero, b_zero, code_ok;

    assign a_nan   = (opnd_a[30:23] == 8'hFF) && (opnd_a[22:0] != 23'd0);
    assign b_nan   = (opnd_b[30:23] == 8'hFF) && (opnd_b[22:0] != 23'd0);
    assign a_zero  = opnd_a[30:0] == 31'd0;
    assign b_zero  = opnd_b[30:0] == 31'd0;
    assign code_ok = (cmp_sel == 4'd14) || (cmp_sel[2:1] != 2'b11);

    if (REG_OUT) begin : g_seq
        // R7: legal strobe yields a write one cycle later
        p_write_follows_r7: assert property (@(posedge clk) disable iff (rst)
            (cmp_valid && code_ok) |=> flag_we);
        // R7: illegal code gives no write and keeps the flag
        p_illegal_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (cmp_valid && !code_ok) |=> (!flag_we && $stable(flag_out)));
        // R9: idle cycle keeps the flag
        p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
            !cmp_valid |=> (!flag_we && !flag_invalid && $stable(flag_out)));
        // R5: bare unordered test
        p_unord_r5: assert property (@(posedge clk) disable iff (rst)
            (cmp_valid && cmp_sel == 4'd14) |=> (flag_out == $past(a_nan || b_nan)));
        // R2: signed zeros are equal
        p_zero_eq_r2: assert property (@(posedge clk) disable iff (rst)
            (cmp_valid && cmp_sel == 4'd0 && a_zero && b_zero) |=> flag_out);
        // R1: ordered predicates are false on NaN
        p_ordered_nan_r1: assert property (@(posedge clk) disable iff (rst)
            (cmp_valid && !cmp_sel[3] && code_ok && (a_nan || b_nan)) |=> !flag_out);
    end

    // R6: invalid only accompanies a write
    always_comb begin
        if (!rst) p_inv_with_we_r6: assert (!flag_invalid || flag_we);
    end
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmp_valid    (cmp_valid),
    .cmp_sel      (cmp_sel),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .flag_out     (flag_out),
    .flag_we      (flag_we),
    .flag_invalid (flag_invalid)
);

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_valid = 1'b0;
    logic [3:0]  cmp_sel = 4'd0;
    logic [31:0] opnd_a = 32'd0;
    logic [31:0] opnd_b = 32'd0;
    logic        flag_out, flag_we, flag_invalid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fcmp_flag_unit u_dut (
        .clk          (clk),
        .rst          (rst),
        .cmp_valid    (cmp_valid),
        .cmp_sel      (cmp_sel),
        .opnd_a       (opnd_a),
        .opnd_b       (opnd_b),
        .flag_out     (flag_out),
        .flag_we      (flag_we),
        .flag_invalid (flag_invalid)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [3:0]  sel;
        logic [31:0] a;
        logic [31:0] b;
        logic        flag;
        logic        inv;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{"R2", 4'd0,  32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0},
        '{"R2", 4'd4,  32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{"R3", 4'd4,  32'hC000_0000, 32'hBF80_0000, 1'b1, 1'b0},
        '{"R3", 4'd2,  32'h8000_0001, 32'h0000_0001, 1'b0, 1'b0},
        '{"R3", 4'd4,  32'hFF80_0000, 32'hFF7F_FFFF, 1'b1, 1'b0},
        '{"R1", 4'd1,  32'h7FC0_0000, 32'h3F80_0000, 1'b0, 1'b0},
        '{"R4", 4'd9,  32'h7FC0_0000, 32'h3F80_0000, 1'b1, 1'b0},
        '{"R5", 4'd14, 32'h3F80_0000, 32'h3F80_0000, 1'b0, 1'b0},
        '{"R6", 4'd14, 32'h3F80_0000, 32'h7F80_0001, 1'b1, 1'b1},
        '{"R6", 4'd8,  32'h7FC0_0001, 32'h3F80_0000, 1'b1, 1'b0}
    };

    localparam int NS = 14;
    localparam logic [31:0] SWEEP [NS] = '{
        32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
        32'h4000_0000, 32'hC000_0000, 32'h0000_0001, 32'h8000_0001,
        32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000, 32'h7F80_0001,
        32'h7F7F_FFFF, 32'hBFC0_0000
    };

    function automatic bit is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
    endfunction

    function automatic bit is_snan(input logic [31:0] v);
        return is_nan(v) && !v[22];
    endfunction

    function automatic int order_key(input logic [31:0] v);
        int m;
        m = int'({1'b0, v[30:0]});
        return v[31] ? -m : m;
    endfunction

    function automatic bit ref_flag(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
        bit un, r;
        int ka, kb;
        un = is_nan(a) || is_nan(b);
        ka = order_key(a);
        kb = order_key(b);
        case (s[2:0])
            3'd0: r = ka == kb;
            3'd1: r = ka != kb;
            3'd2: r = ka > kb;
            3'd3: r = ka >= kb;
            3'd4: r = ka < kb;
            3'd5: r = ka <= kb;
            default: r = 1'b0;
        endcase
        if (s == 4'd14) return un;
        if (s[3])       return un || r;
        return !un && r;
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {we,flag,inv} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic issue(input bit v, input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cmp_valid = v;
        cmp_sel   = s;
        opnd_a    = a;
        opnd_b    = b;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        string tag;
        bit    ef;
        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8", {flag_we, flag_out, flag_invalid}, 3'b000);
        rst = 1'b0;
        @(negedge clk);
        check("R8", {flag_we, flag_out, flag_invalid}, 3'b000);

        // directed vector table
        for (int i = 0; i < NV; i++) begin
            issue(1'b1, VECS[i].sel, VECS[i].a, VECS[i].b);
            tag = string'(VECS[i].tag);
            check(tag, {flag_we, flag_out, flag_invalid}, {1'b1, VECS[i].flag, VECS[i].inv});
        end

        // sweep of all predicates over the operand classes (R1 R3 R4 R5 R6)
        for (int p = 0; p < 16; p++) begin
            if (p == 6 || p == 7 || p == 15) continue;
            for (int i = 0; i < NS; i++) begin
                for (int j = 0; j < NS; j++) begin
                    issue(1'b1, 4'(p), SWEEP[i], SWEEP[j]);
                    ef = ref_flag(4'(p), SWEEP[i], SWEEP[j]);
                    tag = (p == 14) ? "R5" : (p >= 8) ? "R4" : "R1";
                    check(tag, {flag_we, flag_out, flag_invalid},
                          {1'b1, ef, is_snan(SWEEP[i]) || is_snan(SWEEP[j])});
                end
            end
        end

        // R7: illegal codes do not write and hold the flag
        issue(1'b1, 4'd14, 32'h7FC0_0000, 32'h0);
        check("R7", {flag_we, flag_out, flag_invalid}, 3'b110);
        issue(1'b1, 4'd6, 32'h3F80_0000, 32'h3F80_0000);
        check("R7", {flag_we, flag_out, flag_invalid}, 3'b010);
        issue(1'b1, 4'd7, 32'h7F80_0001, 32'h3F80_0000);
        check("R7", {flag_we, flag_out, flag_invalid}, 3'b010);
        issue(1'b1, 4'd15, 32'h3F80_0000, 32'h4000_0000);
        check("R7", {flag_we, flag_out, flag_invalid}, 3'b010);

        // R9: no strobe, inputs that would clear the flag are ignored
        issue(1'b0, 4'd14, 32'h3F80_0000, 32'h3F80_0000);
        check("R9", {flag_we, flag_out, flag_invalid}, 3'b010);
        issue(1'b1, 4'd2, 32'h3F80_0000, 32'h4000_0000);
        check("R9", {flag_we, flag_out, flag_invalid}, 3'b100);
        issue(1'b0, 4'd5, 32'h3F80_0000, 32'h4000_0000);
        check("R9", {flag_we, flag_out, flag_invalid}, 3'b000);

        // R8: reset mid-run clears a set flag
        issue(1'b1, 4'd14, 32'h7F80_0001, 32'h0);
        check("R6", {flag_we, flag_out, flag_invalid}, 3'b111);
        rst = 1'b1;
        @(negedge clk);
        check("R8", {flag_we, flag_out, flag_invalid}, 3'b000);
        rst = 1'b0;
        @(negedge clk);
        check("R8", {flag_we, flag_out, flag_invalid}, 3'b000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule